// File: doc/BRIEF.md
# PCM Serial Sample Shifter with Selectable MSB Alignment

This block moves 16-bit audio samples across a PCM serial link. On the transmit side it takes a parallel sample from a show-ahead FIFO at the start of each frame and shifts it out MSB first on a serial data output. On the receive side it assembles incoming serial bits into a parallel sample and presents it with a one-cycle valid pulse. The bit clock and frame sync come from elsewhere. The block samples them in the system clock domain through a two-stage synchronizer, and it detects the bit clock edges after that synchronizer.

Two independent alignment inputs choose where the MSB sits in the frame. At 0 the MSB occupies the bit clock cycle in which frame sync is high. At 1 it occupies the following bit clock cycle. One input controls transmit and the other controls receive. Transmit bits change after a rising bit clock edge. Receive bits are captured on the falling edge. If the transmit FIFO is empty at frame start, the frame carries zeros and an underrun pulse is raised.

Top module: `pcm_msb_port`

## Requirements
- R1: After reset, `sdout` is low and `tx_pop`, `tx_underrun` and `rx_valid` are all low until frame activity occurs.
- R2: With `tx_msb_late`=0, bit 15 of the sample is on `sdout` during the bit clock cycle in which `fsync` is high. Bits 14 down to 0 follow, one per bit clock cycle.
- R3: With `tx_msb_late`=1, `sdout` is low during the frame sync cycle. Bit 15 appears in the next bit clock cycle and is followed by bits 14 down to 0.
- R4: Once the 16th bit has been sent, `sdout` stays low on every bit clock cycle until the next frame sync. A bit clock with no frame sync also leaves it low.
- R5: At each frame start where `tx_valid`=1, `tx_pop` pulses once and `tx_data` is sent. Where `tx_valid`=0, `tx_underrun` pulses once, `tx_pop` stays low and all 16 bits are sent as 0.
- R6: `sdin` is captured on falling bit clock edges. With `rx_msb_late`=0, the bit captured in the frame sync cycle becomes bit 15 of `rx_data`.
- R7: With `rx_msb_late`=1, the bit captured in the cycle after frame sync becomes bit 15. The bit in the frame sync cycle is discarded.
- R8: After the 16th bit is captured, `rx_valid` is high for exactly one system clock cycle with the assembled sample on `rx_data`. Serial traffic without a frame sync produces no pulse.
- R9: Transmit and receive alignment act independently. A frame with different settings on the two inputs still meets R2/R3 and R6/R7 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| fsync | input | 1 | Frame sync, high for one bit clock cycle per frame |
| sdin | input | 1 | Serial receive data |
| tx_msb_late | input | 1 | Transmit MSB alignment: 0 = frame sync cycle, 1 = next cycle |
| rx_msb_late | input | 1 | Receive MSB alignment: 0 = frame sync cycle, 1 = next cycle |
| tx_data | input | 16 | Head of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_pop | output | 1 | One-cycle pop strobe toward the transmit FIFO |
| tx_underrun | output | 1 | One-cycle pulse when a frame starts with no sample |
| sdout | output | 1 | Serial transmit data |
| rx_data | output | 16 | Received sample |
| rx_valid | output | 1 | One-cycle strobe marking `rx_data` |

## Verification
The hardest case to reach from the ports is a frame in which the two alignment inputs differ while transmit and receive run together. In that frame the transmitted MSB and the captured MSB sit one bit clock apart. A shared off-by-one error would therefore cancel out in a loopback test but not in this one. The stimulus drives each bit clock cycle by hand, placing the receive bits according to `rx_msb_late` and checking each transmit bit against `tx_msb_late`. It runs all four combinations of the two settings and mixes in an underrun frame and a frame with no sync, so that idle-low output and suppressed capture are each seen once.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int SAMPLE_W = 16;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic sdin_i,
  output logic bclk_rise_o,
  output logic bclk_fall_o,
  output logic fsync_o,
  output logic sdin_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] stage_q [STAGES];
  logic            bclk_last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [NSIG-1:0] stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = {sdin_i, fsync_i, bclk_i};
      end else begin : g_next
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_last_q <= 1'b0;
    else        bclk_last_q <= stage_q[STAGES-1][0];
  end

  always_comb begin
    bclk_rise_o = stage_q[STAGES-1][0] & ~bclk_last_q;
    bclk_fall_o = ~stage_q[STAGES-1][0] & bclk_last_q;
    fsync_o     = stage_q[STAGES-1][1];
    sdin_o      = stage_q[STAGES-1][2];
  end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          fsync_i,
  input  logic          msb_late_i,
  input  logic [SW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_pop_o,
  output logic          tx_underrun_o,
  output logic          sdout_o
);
  localparam int CW = $clog2(SW + 1);

  logic [SW-1:0] sreg_q, sreg_d, load_w;
  logic [CW-1:0] left_q, left_d;
  logic          pend_q, pend_d;
  logic          sdout_q, sdout_d;
  logic          pop_q, pop_d, unr_q, unr_d;

  always_comb begin
    sreg_d  = sreg_q;
    left_d  = left_q;
    pend_d  = pend_q;
    sdout_d = sdout_q;
    pop_d   = 1'b0;
    unr_d   = 1'b0;
    load_w  = tx_valid_i ? tx_data_i : '0;
    if (rise_i) begin
      if (fsync_i) begin
        pop_d = tx_valid_i;
        unr_d = ~tx_valid_i;
        if (!msb_late_i) begin
          sdout_d = load_w[SW-1];
          sreg_d  = load_w << 1;
          left_d  = CW'(SW - 1);
          pend_d  = 1'b0;
        end else begin
          sdout_d = 1'b0;
          sreg_d  = load_w;
          left_d  = '0;
          pend_d  = 1'b1;
        end
      end else if (pend_q) begin
        sdout_d = sreg_q[SW-1];
        sreg_d  = sreg_q << 1;
        left_d  = CW'(SW - 1);
        pend_d  = 1'b0;
      end else if (left_q != '0) begin
        sdout_d = sreg_q[SW-1];
        sreg_d  = sreg_q << 1;
        left_d  = left_q - 1'b1;
      end else begin
        sdout_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      left_q  <= '0;
      pend_q  <= 1'b0;
      sdout_q <= 1'b0;
      pop_q   <= 1'b0;
      unr_q   <= 1'b0;
    end else begin
      sreg_q  <= sreg_d;
      left_q  <= left_d;
      pend_q  <= pend_d;
      sdout_q <= sdout_d;
      pop_q   <= pop_d;
      unr_q   <= unr_d;
    end
  end

  assign tx_pop_o      = pop_q;
  assign tx_underrun_o = unr_q;
  assign sdout_o       = sdout_q;

  // R5: a pop is only issued for a sample that was offered
  p_pop_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_o |-> $past(tx_valid_i));
  // R5: pop and underrun never coincide
  p_pop_unr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pop_o && tx_underrun_o));
  // R4: an idle bit cycle drives the line low
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !fsync_i && !pend_q && left_q == '0) |=> !sdout_o);
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_i,
  input  logic          fsync_i,
  input  logic          sdin_i,
  input  logic          msb_late_i,
  output logic [SW-1:0] rx_data_o,
  output logic          rx_valid_o
);
  localparam int CW = $clog2(SW + 1);

  logic [SW-1:0] sh_q, sh_d, data_q, data_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d, vld_q, vld_d;

  always_comb begin
    sh_d   = sh_q;
    data_d = data_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    vld_d  = 1'b0;
    if (fall_i) begin
      if (fsync_i) begin
        act_d = 1'b1;
        if (!msb_late_i) begin
          sh_d  = {sh_q[SW-2:0], sdin_i};
          cnt_d = CW'(1);
        end else begin
          cnt_d = '0;
        end
      end else if (act_q) begin
        sh_d = {sh_q[SW-2:0], sdin_i};
        if (cnt_q == CW'(SW - 1)) begin
          data_d = {sh_q[SW-2:0], sdin_i};
          vld_d  = 1'b1;
          act_d  = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      vld_q  <= vld_d;
    end
  end

  assign rx_data_o  = data_q;
  assign rx_valid_o = vld_q;

  // R8: valid is a single-cycle strobe
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  // R8: bit counter never passes the sample width
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(SW));
endmodule

// File: rtl/pcm_msb_port.sv
module pcm_msb_port
  import pcm_port_pkg::*;
#(
  parameter int SW     = SAMPLE_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          fsync,
  input  logic          sdin,
  input  logic          tx_msb_late,
  input  logic          rx_msb_late,
  input  logic [SW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_pop,
  output logic          tx_underrun,
  output logic          sdout,
  output logic [SW-1:0] rx_data,
  output logic          rx_valid
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       rise_w, fall_w, fs_w, sd_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pcm_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .bclk_i(bclk), .fsync_i(fsync), .sdin_i(sdin),
    .bclk_rise_o(rise_w), .bclk_fall_o(fall_w),
    .fsync_o(fs_w), .sdin_o(sd_w)
  );

  pcm_tx_shift #(.SW(SW)) u_tx (
    .clk(clk), .rst_n(rst_sync_n),
    .rise_i(rise_w), .fsync_i(fs_w), .msb_late_i(tx_msb_late),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_pop_o(tx_pop), .tx_underrun_o(tx_underrun), .sdout_o(sdout)
  );

  pcm_rx_shift #(.SW(SW)) u_rx (
    .clk(clk), .rst_n(rst_sync_n),
    .fall_i(fall_w), .fsync_i(fs_w), .sdin_i(sd_w),
    .msb_late_i(rx_msb_late),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  // R6: a sample is only presented right after a falling bit clock edge
  p_valid_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid |-> $past(fall_w));
  // R5: frame-start strobes only follow a rising bit clock edge
  p_strobe_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_pop || tx_underrun) |-> $past(rise_w));
endmodule

// File: tb/pcm_msb_port_tb.sv
module pcm_msb_port_tb;
  localparam int SW = 16;
  localparam int NB = 20;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
  logic tx_msb_late = 1'b0, rx_msb_late = 1'b0;
  logic [SW-1:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_pop, tx_underrun, sdout, rx_valid;
  logic [SW-1:0] rx_data;

  int checks = 0, fails = 0;
  int pop_cnt = 0, unr_cnt = 0;
  bit done = 1'b0;
  logic [SW-1:0] exp_q[$];

  always #2 clk = ~clk;

  pcm_msb_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
    .tx_msb_late(tx_msb_late), .rx_msb_late(rx_msb_late),
    .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_pop(tx_pop), .tx_underrun(tx_underrun), .sdout(sdout),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard for received samples and strobe counters
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_pop) pop_cnt++;
      if (tx_underrun) unr_cnt++;
      if (rx_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected rx_valid", rx_data, 0);
        else begin
          logic [SW-1:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, rx_msb_late ? "R7 rx sample" : "R6 rx sample", rx_data, e);
        end
      end
    end
  end

  // driver: one frame of NB bit clock cycles
  task automatic frame(input bit do_fs, input bit txl, input bit rxl,
                       input bit avail, input logic [SW-1:0] txw,
                       input logic [SW-1:0] rxw);
    logic [SW-1:0] got, exp_tx;
    bit idle_ok;
    int p0, u0;
    got = '0;
    idle_ok = 1'b1;
    p0 = pop_cnt;
    u0 = unr_cnt;
    exp_tx = avail ? txw : '0;
    @(negedge clk);
    tx_msb_late = txl;
    rx_msb_late = rxl;
    tx_valid = avail;
    tx_data = txw;
    if (do_fs) exp_q.push_back(rxw);
    for (int i = 0; i < NB; i++) begin
      int kr, kt;
      kr = i - int'(rxl);
      kt = i - int'(txl);
      @(negedge clk);
      bclk = 1'b1;
      fsync = do_fs && (i == 0);
      sdin = (do_fs && kr >= 0 && kr < SW) ? rxw[SW-1-kr] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (do_fs && kt >= 0 && kt < SW) got[SW-1-kt] = sdout;
      else if (sdout !== 1'b0) idle_ok = 1'b0;
      bclk = 1'b0;
      if (i == 1) tx_valid = 1'b0;
      repeat (HALF - 1) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    if (do_fs) chk(got == exp_tx, txl ? "R3 tx word" : "R2 tx word", got, exp_tx);
    chk(idle_ok, "R4 sdout low outside sample bits", idle_ok, 1);
    chk(pop_cnt - p0 == int'(do_fs && avail), "R5 tx_pop count", pop_cnt - p0, int'(do_fs && avail));
    chk(unr_cnt - u0 == int'(do_fs && !avail), "R5 tx_underrun count", unr_cnt - u0, int'(do_fs && !avail));
    chk(exp_q.size() == 0, "R8 rx sample count", exp_q.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sdout == 1'b0, "R1 sdout after reset", sdout, 0);
    chk(rx_valid == 1'b0 && tx_pop == 1'b0, "R1 strobes after reset", {rx_valid, tx_pop}, 0);
    chk(tx_underrun == 1'b0, "R1 underrun after reset", tx_underrun, 0);
    frame(1, 0, 0, 1, 16'hA5C3, 16'h8001);   // R2 R6
    frame(1, 1, 1, 1, 16'h9E21, 16'hC0DE);   // R3 R7
    frame(1, 1, 0, 1, 16'h8F0F, 16'h7FFE);   // R9 mixed
    frame(1, 0, 1, 1, 16'h0001, 16'hB00B);   // R9 mixed
    frame(1, 0, 0, 0, 16'hFFFF, 16'h1234);   // R5 underrun
    frame(0, 0, 0, 1, 16'hFFFF, 16'hFFFF);   // R4 R8 no frame sync
    frame(1, 1, 1, 0, 16'h5555, 16'hFFFF);   // R5 underrun late
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule